// File: doc/BRIEF.md
# I2C Slave No-Stretch Buffer Guard

This block sits beside the byte engine of an I2C slave that has been set up never to hold SCL low. In that setup the bus cannot be paused while software catches up. The block therefore decides, in the same cycle the engine asks, how to answer when software is late. It chooses ACK or NACK for each incoming byte, and it chooses which byte goes out next. When software has fallen behind, the incoming byte is dropped and refused, or an all-ones fill byte replaces the missing data. Each such event is latched in a sticky error flag that software clears, and that flag drives an interrupt only while the error-interrupt enable is set.

The engine talks to the block through single-cycle strobes: a byte has arrived, a byte must be sent, and a STOP was seen. The block answers combinationally in the same cycle. Software sees a one-byte receive holding register with a full bit, a one-byte transmit holding register with an empty bit, the error flag and the interrupt line.

Top module: `i2c_nostretch_guard`

## Requirements
- R1: After reset, rx_full=0, rx_data=0, tx_empty=1, ovr_flag=0 and irq=0.
- R2: An arriving byte (byte_received=1) while rx_full=0 is acknowledged in the same cycle (ack_out=1), is stored in rx_data, and sets rx_full at the next clock edge.
- R3: With guard mode active (cfg_slave=1 and cfg_nostretch=1), an arriving byte while rx_full=1 and no read strobe is present is refused (ack_out=0) and discarded, rx_data keeps the earlier byte, and the event counts as an overrun.
- R4: A sw_rx_read strobe clears rx_full at the next edge. A read in the same cycle as an arrival empties the register first, so the new byte is stored and acknowledged.
- R5: On need_tx_byte with tx_empty=0, tx_byte_out carries the held byte in the same cycle and tx_empty is set at the next edge. This also applies to the first byte after a STOP.
- R6: With guard mode active, need_tx_byte while tx_empty=1 drives 0xFF (all ones) on tx_byte_out and counts as an underrun. This applies to the first byte after a STOP and to any later byte.
- R7: A sw_tx_write strobe loads sw_tx_data and clears tx_empty at the next edge. A write in the same cycle as need_tx_byte is too late for that byte and is kept for the next one.
- R8: ovr_flag is set at the edge after any overrun or underrun and stays set until an ovr_clear strobe. A clear in the same cycle as a new event leaves the flag set.
- R9: irq equals ovr_flag AND cfg_err_ie (same cycle as the flag with IRQ_REG=0).
- R10: With guard mode inactive (cfg_slave=0 or cfg_nostretch=0), no event is flagged: an arriving byte is always acknowledged and overwrites rx_data, and need_tx_byte always sends the held byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_slave | input | 1 | Peripheral is in slave role |
| cfg_nostretch | input | 1 | Clock stretching disabled |
| cfg_err_ie | input | 1 | Error interrupt enable |
| byte_received | input | 1 | Engine strobe: a byte has been shifted in |
| rx_byte_in | input | DATA_W | Byte from the engine |
| ack_out | output | 1 | Answer to the arriving byte (1 = ACK) |
| need_tx_byte | input | 1 | Engine strobe: next byte to send is needed |
| tx_byte_out | output | DATA_W | Byte handed to the engine |
| stop_detected | input | 1 | Engine strobe: STOP seen on the bus |
| sw_rx_read | input | 1 | Software reads the receive register |
| rx_data | output | DATA_W | Receive holding register |
| rx_full | output | 1 | Receive register holds an unread byte |
| sw_tx_write | input | 1 | Software writes the transmit register |
| sw_tx_data | input | DATA_W | Data written by software |
| tx_empty | output | 1 | Transmit register holds no unsent byte |
| ovr_clear | input | 1 | Write-one clear of the error flag |
| ovr_flag | output | 1 | Sticky overrun/underrun flag |
| irq | output | 1 | Gated error interrupt |

## Verification
ack_out and tx_byte_out are due in the same cycle as their strobe. The bench reads them one nanosecond after driving the inputs on the falling edge, before the next rising edge. rx_full, rx_data, tx_empty, ovr_flag and irq change at the first rising edge after the stimulus. The bench reads them one nanosecond after that edge, while the inputs of the vector are still held. The interrupt is therefore compared in the same sample as the flag.

// File: rtl/i2c_nsg_pkg.sv
package i2c_nsg_pkg;
   typedef enum logic {
      TXSRC_HOLD = 1'b0,
      TXSRC_FILL = 1'b1
   } tx_src_e;

   function automatic logic [63:0] fill_pattern();
      return '1;
   endfunction
endpackage

// File: rtl/nsg_rx_hold.sv
module nsg_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              guard_on,
   input  logic              byte_received,
   input  logic [DATA_W-1:0] rx_byte_in,
   input  logic              sw_rx_read,
   output logic              ack_out,
   output logic              ovr_evt,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full
);
   logic occupied;
   logic take;

   // a same-cycle read frees the slot before the arriving byte is judged
   assign occupied = rx_full && !sw_rx_read;
   assign take     = byte_received && (!occupied || !guard_on);
   assign ack_out  = take;
   assign ovr_evt  = byte_received && occupied && guard_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
      end else begin
         if (take) begin
            rx_data <= rx_byte_in;
            rx_full <= 1'b1;
         end else if (sw_rx_read) begin
            rx_full <= 1'b0;
         end
      end
   end

   assert_refused_keeps_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_received && rx_full && !sw_rx_read && guard_on) |=> (rx_full && $stable(rx_data)));

   assert_read_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rx_read && !byte_received) |=> !rx_full);

   assert_accept_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_received && !rx_full) |=> rx_full);
endmodule

// File: rtl/nsg_tx_hold.sv
module nsg_tx_hold
   import i2c_nsg_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              guard_on,
   input  logic              need_tx_byte,
   input  logic              stop_detected,
   input  logic              sw_tx_write,
   input  logic [DATA_W-1:0] sw_tx_data,
   output logic [DATA_W-1:0] tx_byte_out,
   output logic              udr_evt,
   output logic              tx_empty
);
   localparam logic [DATA_W-1:0] FILL = fill_pattern()[DATA_W-1:0];

   logic [DATA_W-1:0] hold_q;
   logic              first_pend;
   tx_src_e           src;

   always_comb begin
      src = (guard_on && tx_empty) ? TXSRC_FILL : TXSRC_HOLD;
      tx_byte_out = (src == TXSRC_FILL) ? FILL : hold_q;
   end

   assign udr_evt = need_tx_byte && (src == TXSRC_FILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q     <= '0;
         tx_empty   <= 1'b1;
         first_pend <= 1'b0;
      end else begin
         if (sw_tx_write) begin
            hold_q   <= sw_tx_data;
            tx_empty <= 1'b0;
         end else if (need_tx_byte) begin
            tx_empty <= 1'b1;
         end
         if (stop_detected)     first_pend <= 1'b1;
         else if (need_tx_byte) first_pend <= 1'b0;
      end
   end

   // first byte of a new transfer follows the same empty/fill rule
   assert_first_byte_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (need_tx_byte && first_pend && guard_on) |-> (udr_evt == tx_empty));

   assert_send_marks_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (need_tx_byte && !sw_tx_write) |=> tx_empty);

   assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_tx_write |=> (!tx_empty && tx_byte_out == $past(sw_tx_data)));
endmodule

// File: rtl/nsg_err_flag.sv
module nsg_err_flag #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_a,
   input  logic evt_b,
   input  logic clr,
   input  logic err_ie,
   output logic flag,
   output logic irq
);
   logic any_evt;
   assign any_evt = evt_a || evt_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (any_evt) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= (flag || any_evt) && !(clr && !any_evt) && err_ie;
         end
      end else begin : g_irq_comb
         assign irq = flag && err_ie;
         assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !err_ie |-> !irq);
      end
   endgenerate

   assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> flag);

   assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !any_evt) |=> !flag);
endmodule

// File: rtl/i2c_nostretch_guard.sv
module i2c_nostretch_guard #(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_slave,
   input  logic              cfg_nostretch,
   input  logic              cfg_err_ie,
   input  logic              byte_received,
   input  logic [DATA_W-1:0] rx_byte_in,
   output logic              ack_out,
   input  logic              need_tx_byte,
   output logic [DATA_W-1:0] tx_byte_out,
   input  logic              stop_detected,
   input  logic              sw_rx_read,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   input  logic              sw_tx_write,
   input  logic [DATA_W-1:0] sw_tx_data,
   output logic              tx_empty,
   input  logic              ovr_clear,
   output logic              ovr_flag,
   output logic              irq
);
   initial begin
      assert (DATA_W >= 2 && DATA_W <= 64)
         else $error("DATA_W out of supported range");
   end

   logic guard_on;
   logic rx_ovr;
   logic tx_udr;

   assign guard_on = cfg_slave && cfg_nostretch;

   nsg_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .guard_on      (guard_on),
      .byte_received (byte_received),
      .rx_byte_in    (rx_byte_in),
      .sw_rx_read    (sw_rx_read),
      .ack_out       (ack_out),
      .ovr_evt       (rx_ovr),
      .rx_data       (rx_data),
      .rx_full       (rx_full)
   );

   nsg_tx_hold #(.DATA_W(DATA_W)) u_tx (
      .clk           (clk),
      .rst_n         (rst_n),
      .guard_on      (guard_on),
      .need_tx_byte  (need_tx_byte),
      .stop_detected (stop_detected),
      .sw_tx_write   (sw_tx_write),
      .sw_tx_data    (sw_tx_data),
      .tx_byte_out   (tx_byte_out),
      .udr_evt       (tx_udr),
      .tx_empty      (tx_empty)
   );

   nsg_err_flag #(.IRQ_REG(IRQ_REG)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_a  (rx_ovr),
      .evt_b  (tx_udr),
      .clr    (ovr_clear),
      .err_ie (cfg_err_ie),
      .flag   (ovr_flag),
      .irq    (irq)
   );

   assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!guard_on && !ovr_flag) |=> !ovr_flag);
endmodule

// File: tb/i2c_nostretch_guard_test.sv
`timescale 1ns/1ps
module i2c_nostretch_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_slave = 0, cfg_nostretch = 0, cfg_err_ie = 0;
   logic       byte_received = 0, need_tx_byte = 0, stop_detected = 0;
   logic [7:0] rx_byte_in = 0, sw_tx_data = 0;
   logic       sw_rx_read = 0, sw_tx_write = 0, ovr_clear = 0;
   logic       ack_out, rx_full, tx_empty, ovr_flag, irq;
   logic [7:0] tx_byte_out, rx_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   i2c_nostretch_guard uut (
      .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_nostretch(cfg_nostretch),
      .cfg_err_ie(cfg_err_ie), .byte_received(byte_received), .rx_byte_in(rx_byte_in),
      .ack_out(ack_out), .need_tx_byte(need_tx_byte), .tx_byte_out(tx_byte_out),
      .stop_detected(stop_detected), .sw_rx_read(sw_rx_read), .rx_data(rx_data),
      .rx_full(rx_full), .sw_tx_write(sw_tx_write), .sw_tx_data(sw_tx_data),
      .tx_empty(tx_empty), .ovr_clear(ovr_clear), .ovr_flag(ovr_flag), .irq(irq)
   );

   typedef struct packed {
      logic en, ns, ie, rcv;
      logic [7:0] rxb;
      logic rd, need, wr;
      logic [7:0] wd;
      logic stop, clr, eack;
      logic [7:0] etx;
      logic efull;
      logic [7:0] erxd;
      logic etxe, eovr, eirq;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VEC [NV] = '{
      '{1,1,1,1,8'hA5,0,0,0,8'h00,0,0,1,8'h00,1,8'hA5,1,0,0},
      '{1,1,1,1,8'h3C,0,0,0,8'h00,0,0,0,8'h00,1,8'hA5,1,1,1},
      '{1,1,1,0,8'h00,0,0,0,8'h00,0,1,0,8'h00,1,8'hA5,1,0,0},
      '{1,1,1,1,8'h77,1,0,0,8'h00,0,0,1,8'h00,1,8'h77,1,0,0},
      '{1,1,1,0,8'h00,1,0,0,8'h00,0,0,0,8'h00,0,8'h77,1,0,0},
      '{1,1,1,0,8'h00,0,1,0,8'h00,0,0,0,8'hFF,0,8'h77,1,1,1},
      '{1,1,1,0,8'h00,0,0,1,8'h5A,0,1,0,8'h00,0,8'h77,0,0,0},
      '{1,1,1,0,8'h00,0,1,0,8'h00,0,0,0,8'h5A,0,8'h77,1,0,0},
      '{1,1,1,0,8'h00,0,1,0,8'h00,0,0,0,8'hFF,0,8'h77,1,1,1},
      '{1,1,0,1,8'h11,0,0,0,8'h00,0,1,1,8'h00,1,8'h11,1,0,0},
      '{1,1,0,1,8'h22,0,0,0,8'h00,0,0,0,8'h00,1,8'h11,1,1,0},
      '{1,1,1,1,8'h33,0,0,0,8'h00,0,1,0,8'h00,1,8'h11,1,1,1},
      '{1,0,1,1,8'h44,0,0,0,8'h00,0,1,1,8'h00,1,8'h44,1,0,0},
      '{1,0,1,0,8'h00,0,1,0,8'h00,0,0,0,8'h5A,1,8'h44,1,0,0},
      '{1,1,1,0,8'h00,0,0,1,8'hC3,1,0,0,8'h00,1,8'h44,0,0,0},
      '{1,1,1,0,8'h00,0,1,0,8'h00,0,0,0,8'hC3,1,8'h44,1,0,0},
      '{1,1,1,0,8'h00,0,1,1,8'h99,0,0,0,8'hFF,1,8'h44,0,1,1},
      '{1,1,1,0,8'h00,0,1,0,8'h00,0,1,0,8'h99,1,8'h44,1,0,0}
   };

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      byte_received = 0; need_tx_byte = 0; stop_detected = 0;
      sw_rx_read = 0; sw_tx_write = 0; ovr_clear = 0;
   endtask

   task automatic check_reset_state(input string tag);
      chk(tag, "rx_full", {7'd0, rx_full}, 8'd0);
      chk(tag, "rx_data", rx_data, 8'h00);
      chk(tag, "tx_empty", {7'd0, tx_empty}, 8'd1);
      chk(tag, "ovr_flag", {7'd0, ovr_flag}, 8'd0);
      chk(tag, "irq", {7'd0, irq}, 8'd0);
   endtask

   initial begin
      #100000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 check_reset_state("R1");
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         cfg_slave = VEC[i].en; cfg_nostretch = VEC[i].ns; cfg_err_ie = VEC[i].ie;
         byte_received = VEC[i].rcv; rx_byte_in = VEC[i].rxb; sw_rx_read = VEC[i].rd;
         need_tx_byte = VEC[i].need; sw_tx_write = VEC[i].wr; sw_tx_data = VEC[i].wd;
         stop_detected = VEC[i].stop; ovr_clear = VEC[i].clr;
         #1;
         if (VEC[i].rcv) chk("R2 R3 R4 R10", $sformatf("ack v%0d", i), {7'd0, ack_out}, {7'd0, VEC[i].eack});
         if (VEC[i].need) chk("R5 R6 R7 R10", $sformatf("tx v%0d", i), tx_byte_out, VEC[i].etx);
         @(posedge clk); #1;
         chk("R2 R3 R4 R10", $sformatf("full v%0d", i), {7'd0, rx_full}, {7'd0, VEC[i].efull});
         chk("R2 R3 R10", $sformatf("rxd v%0d", i), rx_data, VEC[i].erxd);
         chk("R5 R7", $sformatf("txe v%0d", i), {7'd0, tx_empty}, {7'd0, VEC[i].etxe});
         chk("R8 R10", $sformatf("ovr v%0d", i), {7'd0, ovr_flag}, {7'd0, VEC[i].eovr});
         chk("R9", $sformatf("irq v%0d", i), {7'd0, irq}, {7'd0, VEC[i].eirq});
      end

      // R10: slave role off, register full: byte overwrites, ACK, no flag
      @(negedge clk);
      idle_inputs();
      cfg_slave = 0; cfg_nostretch = 1; cfg_err_ie = 1;
      byte_received = 1; rx_byte_in = 8'h55;
      #1 chk("R10", "ack not slave", {7'd0, ack_out}, 8'd1);
      @(posedge clk); #1;
      chk("R10", "rxd not slave", rx_data, 8'h55);
      chk("R10", "ovr not slave", {7'd0, ovr_flag}, 8'd0);

      // R8: flag survives cycles with no strobe
      @(negedge clk);
      idle_inputs();
      cfg_slave = 1; cfg_nostretch = 1;
      byte_received = 1; rx_byte_in = 8'h66;
      @(posedge clk); #1;
      @(negedge clk); idle_inputs();
      repeat (3) @(posedge clk);
      #1 chk("R8", "ovr sticky", {7'd0, ovr_flag}, 8'd1);
      chk("R3", "rxd kept", rx_data, 8'h55);

      // R1: reset in mid-run restores all state
      @(negedge clk); rst_n = 1'b0;
      #1 check_reset_state("R1");
      @(negedge clk); rst_n = 1'b1;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule